// File: doc/BRIEF.md
# Single-Cycle Integer Core for a Six-Instruction Subset

This block is a 32-bit processor core that completes one instruction on every rising clock edge. It fetches a word from a private instruction store, splits it into its fields, reads two operands from a 32-entry register file, and routes them through a three-function ALU. Depending on the opcode, the result goes to the register file, to a private data store, or to the next-PC selection. Six operations are supported: unsigned add, unsigned subtract, OR with a zero-extended constant, word load, word store and branch-on-equal.

Both stores hold 256 words and are indexed with byte addresses. A load port on each store lets a test environment place a program and its data before it starts the core. A set of observation outputs shows the fetch address, the fetched word and any register write committed in the current cycle, so an external model can follow the core step by step.

Top module: `scd_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC becomes 0 and neither the register file nor the data store is written; `dbg_rf_we` stays low while `rst_n` is low. Register and data-store contents survive reset.
- R2: Instructions with op[31:26]=0x00 take rs[25:21], rt[20:16] and rd[15:11]. funct[5:0]=0x21 writes R[rs]+R[rt] to R[rd], funct 0x23 writes R[rs]-R[rt] to R[rd], both modulo 2^32. The PC then advances by 4.
- R3: Op 0x0D writes R[rs] OR {16'h0000, imm16[15:0]} into R[rt], not R[rd], and advances the PC by 4.
- R4: Op 0x23 forms the byte address R[rs]+sign-extended imm16 and loads the data-store word at index address[9:2] into R[rt]. The PC then advances by 4.
- R5: Op 0x2B writes R[rt] to the data-store word at index (R[rs]+sign-extended imm16)[9:2] on the rising edge. It writes no register and advances the PC by 4.
- R6: Op 0x04 compares R[rs] with R[rt] through an ALU subtract and its zero flag. When they are equal, the next PC is PC+4+(sign-extended imm16 << 2); otherwise it is PC+4. Negative offsets branch backwards.
- R7: Register 0 reads as zero. A write aimed at it changes nothing and leaves `dbg_rf_we` low.
- R8: An unknown opcode, or op 0x00 with a funct other than 0x21 or 0x23, writes nothing and advances the PC by 4.
- R9: Each load port writes its word index on the rising edge when its enable is high. The instruction at index PC[9:2] is presented on `dbg_instr` in the same cycle. `dbg_rf_we`, `dbg_rf_waddr` and `dbg_rf_wdata` describe the register write that the coming edge commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the PC |
| imem_ld_we | input | 1 | Instruction-store load enable |
| imem_ld_idx | input | 8 | Instruction-store word index for loading |
| imem_ld_data | input | 32 | Instruction word to load |
| dmem_ld_we | input | 1 | Data-store load enable |
| dmem_ld_idx | input | 8 | Data-store word index for loading |
| dmem_ld_data | input | 32 | Data word to load |
| dbg_pc | output | 32 | Current fetch byte address |
| dbg_instr | output | 32 | Instruction being executed |
| dbg_rf_we | output | 1 | A register is written at the coming edge |
| dbg_rf_waddr | output | 5 | Destination register of that write |
| dbg_rf_wdata | output | 32 | Value written |

## Verification
Some properties need only the fetched word and the observation outputs, so the assertions check them on every cycle:
- which field names the destination for the R-format, OR-immediate and load cases;
- that a store or an unknown opcode writes no register;
- that a zero destination never raises the write strobe;
- that every non-branch advances the PC by four and a branch lands on one of its two legal targets;
- that the PC is zero after a reset edge.

Other behaviours depend on operand values and remembered state, and only the bench's program can show them: the arithmetic and wrap-around results, zero-extension against sign-extension of the constant, which data word a negative offset selects, a store becoming visible to a later load, the taken or not-taken branch decision, and register contents surviving a reset in mid-run.

// File: rtl/scd_pkg.sv
// Package scd_pkg
// Shared encodings for the single-cycle core: opcode and funct values,
// ALU function codes and the decoded control bundle.
// Assumes the fixed 32-bit instruction format with 5-bit register fields.
package scd_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;

    localparam logic [5:0] FN_ADDU  = 6'h21;
    localparam logic [5:0] FN_SUBU  = 6'h23;

    typedef enum logic [2:0] {
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110
    } alu_op_e;

    typedef struct packed {
        logic    dst_is_rd;   // destination from rd rather than rt
        logic    use_imm;     // second ALU operand is the extended constant
        logic    imm_signed;  // sign-extend rather than zero-extend
        alu_op_e alu_op;
        logic    rf_we;
        logic    mem_we;
        logic    mem_to_reg;
        logic    branch;
    } ctrl_t;

endpackage

// File: rtl/scd_wordmem.sv
// Module scd_wordmem
// Word-wide storage with a combinational byte-addressed read, a clocked
// byte-addressed write from the core, and a clocked word-indexed load port.
// Assumes word-aligned accesses; address bits [1:0] and those above the
// index are ignored. The load port wins when both write the same edge.
module scd_wordmem
    import scd_pkg::*;
#(
    parameter int WORDS = 256,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             ld_we,
    input  logic [IDX_W-1:0] ld_idx,
    input  logic [XLEN-1:0]  ld_data,
    input  logic             wr_en,
    input  logic [XLEN-1:0]  addr,
    input  logic [XLEN-1:0]  wr_data,
    output logic [XLEN-1:0]  rd_data
);

    logic [XLEN-1:0]  words [WORDS];
    logic [IDX_W-1:0] idx;
    logic             unused_addr;

    assign idx         = addr[IDX_W+1:2];
    assign unused_addr = ^{addr[XLEN-1:IDX_W+2], addr[1:0]};

    // Read path: asynchronous word select.
    assign rd_data = words[idx];

    // Write path: load port first, then core store.
    always_ff @(posedge clk) begin
        if (ld_we) begin
            words[ld_idx] <= ld_data;
        end else if (wr_en) begin
            words[idx] <= wr_data;
        end
    end

endmodule

// File: rtl/scd_regfile.sv
// Module scd_regfile
// Register file with two asynchronous read ports and one clocked write port.
// Entry 0 is hard-wired to zero: reads return zero and writes are dropped.
// Contents are not reset.
module scd_regfile
    import scd_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic [AW-1:0]   ra_a,
    input  logic [AW-1:0]   ra_b,
    output logic [XLEN-1:0] rd_a,
    output logic [XLEN-1:0] rd_b,
    input  logic            we,
    input  logic [AW-1:0]   wa,
    input  logic [XLEN-1:0] wd
);

    logic [XLEN-1:0] regs [DEPTH];

    // Read ports: entry 0 forced to zero.
    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

    // Write port: entry 0 never stored.
    always_ff @(posedge clk) begin
        if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

endmodule

// File: rtl/scd_alu.sv
// Module scd_alu
// Three-function ALU (add, subtract, OR) with a zero flag on the result.
// Assumes the function code comes from the control decoder; any other
// code yields zero.
module scd_alu
    import scd_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    // Function select.
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/scd_ctrl.sv
// Module scd_ctrl
// Main decoder: maps opcode and funct to the datapath control bundle.
// Any unrecognised pattern decodes to a bundle that writes nothing and
// does not branch, so the core only steps the PC.
module scd_ctrl
    import scd_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    // Opcode and funct decode.
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        case (op)
            OP_RTYPE: begin
                if (funct == FN_ADDU || funct == FN_SUBU) begin
                    ctrl.dst_is_rd = 1'b1;
                    ctrl.rf_we     = 1'b1;
                    ctrl.alu_op    = (funct == FN_SUBU) ? ALU_SUB : ALU_ADD;
                end
            end
            OP_ORI: begin
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_OR;
                ctrl.rf_we   = 1'b1;
            end
            OP_LW: begin
                ctrl.use_imm    = 1'b1;
                ctrl.imm_signed = 1'b1;
                ctrl.rf_we      = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            OP_SW: begin
                ctrl.use_imm    = 1'b1;
                ctrl.imm_signed = 1'b1;
                ctrl.mem_we     = 1'b1;
            end
            OP_BEQ: begin
                ctrl.imm_signed = 1'b1;
                ctrl.alu_op     = ALU_SUB;
                ctrl.branch     = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scd_core.sv
// Module scd_core
// Single-cycle core: fetch, decode, operand read, execute, memory access
// and write-back all settle within one clock; the edge commits the PC,
// the register write and any store. Reset (synchronous, active low) only
// clears the PC and blocks architectural writes while held.
// Assumes the load ports are used while the core is held in reset.
module scd_core
    import scd_pkg::*;
#(
    parameter int IMEM_WORDS = 256,
    parameter int DMEM_WORDS = 256,
    localparam int IMA_W = $clog2(IMEM_WORDS),
    localparam int DMA_W = $clog2(DMEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              imem_ld_we,
    input  logic [IMA_W-1:0]  imem_ld_idx,
    input  logic [XLEN-1:0]   imem_ld_data,
    input  logic              dmem_ld_we,
    input  logic [DMA_W-1:0]  dmem_ld_idx,
    input  logic [XLEN-1:0]   dmem_ld_data,
    output logic [XLEN-1:0]   dbg_pc,
    output logic [XLEN-1:0]   dbg_instr,
    output logic              dbg_rf_we,
    output logic [REG_AW-1:0] dbg_rf_waddr,
    output logic [XLEN-1:0]   dbg_rf_wdata
);

    logic [XLEN-1:0]   pc_q;
    logic [XLEN-1:0]   instr;
    logic [5:0]        f_op;
    logic [5:0]        f_funct;
    logic [REG_AW-1:0] f_rs;
    logic [REG_AW-1:0] f_rt;
    logic [REG_AW-1:0] f_rd;
    logic [15:0]       f_imm;
    logic              unused_shamt;
    ctrl_t             ctrl;
    logic [XLEN-1:0]   rs_val;
    logic [XLEN-1:0]   rt_val;
    logic [XLEN-1:0]   imm_sx;
    logic [XLEN-1:0]   imm_ext;
    logic [XLEN-1:0]   alu_b;
    logic [XLEN-1:0]   alu_y;
    logic              alu_zero;
    logic [XLEN-1:0]   dmem_rdata;
    logic [XLEN-1:0]   wb_data;
    logic [REG_AW-1:0] wb_addr;
    logic              wb_en;
    logic              st_en;
    logic [XLEN-1:0]   pc_plus4;
    logic [XLEN-1:0]   pc_taken;
    logic [XLEN-1:0]   pc_next;

    // Instruction store: read-only from the core side.
    scd_wordmem #(.WORDS(IMEM_WORDS)) u_imem (
        .clk     (clk),
        .ld_we   (imem_ld_we),
        .ld_idx  (imem_ld_idx),
        .ld_data (imem_ld_data),
        .wr_en   (1'b0),
        .addr    (pc_q),
        .wr_data ('0),
        .rd_data (instr)
    );

    // Field split.
    assign f_op         = instr[31:26];
    assign f_rs         = instr[25:21];
    assign f_rt         = instr[20:16];
    assign f_rd         = instr[15:11];
    assign f_funct      = instr[5:0];
    assign f_imm        = instr[15:0];
    assign unused_shamt = ^instr[10:6];

    scd_ctrl u_ctrl (
        .op    (f_op),
        .funct (f_funct),
        .ctrl  (ctrl)
    );

    scd_regfile #(.DEPTH(1 << REG_AW)) u_rf (
        .clk  (clk),
        .ra_a (f_rs),
        .ra_b (f_rt),
        .rd_a (rs_val),
        .rd_b (rt_val),
        .we   (wb_en),
        .wa   (wb_addr),
        .wd   (wb_data)
    );

    // Constant extension and ALU operand select.
    assign imm_sx  = {{(XLEN-16){f_imm[15]}}, f_imm};
    assign imm_ext = ctrl.imm_signed ? imm_sx : {{(XLEN-16){1'b0}}, f_imm};
    assign alu_b   = ctrl.use_imm ? imm_ext : rt_val;

    scd_alu u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data store: stores gated off during reset.
    assign st_en = ctrl.mem_we & rst_n;

    scd_wordmem #(.WORDS(DMEM_WORDS)) u_dmem (
        .clk     (clk),
        .ld_we   (dmem_ld_we),
        .ld_idx  (dmem_ld_idx),
        .ld_data (dmem_ld_data),
        .wr_en   (st_en),
        .addr    (alu_y),
        .wr_data (rt_val),
        .rd_data (dmem_rdata)
    );

    // Write-back select; a write to entry 0 is not a write.
    assign wb_data = ctrl.mem_to_reg ? dmem_rdata : alu_y;
    assign wb_addr = ctrl.dst_is_rd ? f_rd : f_rt;
    assign wb_en   = ctrl.rf_we & rst_n & (wb_addr != '0);

    // Next-PC: sequential or word-offset branch.
    assign pc_plus4 = pc_q + XLEN'(4);
    assign pc_taken = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
    assign pc_next  = (ctrl.branch && alu_zero) ? pc_taken : pc_plus4;

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign dbg_pc       = pc_q;
    assign dbg_instr    = instr;
    assign dbg_rf_we    = wb_en;
    assign dbg_rf_waddr = wb_addr;
    assign dbg_rf_wdata = wb_data;

endmodule

// File: rtl/scd_core_chk.sv
// Module scd_core_chk
// Assertion checker bound to scd_core. It watches only the observation
// outputs and decodes the fetched word itself.
module scd_core_chk
    import scd_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   dbg_pc,
    input logic [XLEN-1:0]   dbg_instr,
    input logic              dbg_rf_we,
    input logic [REG_AW-1:0] dbg_rf_waddr,
    input logic [XLEN-1:0]   dbg_rf_wdata
);

    logic [5:0]        c_op;
    logic [5:0]        c_fn;
    logic [REG_AW-1:0] c_rt;
    logic [REG_AW-1:0] c_rd;
    logic [XLEN-1:0]   c_boff;
    logic              c_known;
    logic              rst_low_q;
    logic              unused_wdata;

    assign c_op         = dbg_instr[31:26];
    assign c_fn         = dbg_instr[5:0];
    assign c_rt         = dbg_instr[20:16];
    assign c_rd         = dbg_instr[15:11];
    assign c_boff       = {{(XLEN-18){dbg_instr[15]}}, dbg_instr[15:0], 2'b00};
    assign unused_wdata = ^dbg_rf_wdata;
    assign c_known      = (c_op == OP_ORI) || (c_op == OP_LW) || (c_op == OP_SW)
                       || (c_op == OP_BEQ)
                       || ((c_op == OP_RTYPE) && ((c_fn == FN_ADDU) || (c_fn == FN_SUBU)));

    // Remember whether the previous edge saw reset.
    always_ff @(posedge clk) begin
        rst_low_q <= !rst_n;
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_low_q) begin
            reset_pc_chk: assert (dbg_pc == '0)
                else $error("PC not zero after reset edge");
        end
    end

    // R7
    zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_rf_we |-> (dbg_rf_waddr != '0));

    // R2
    rtype_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_op == OP_RTYPE) && ((c_fn == FN_ADDU) || (c_fn == FN_SUBU)) && (c_rd != '0))
        |-> (dbg_rf_we && (dbg_rf_waddr == c_rd)));

    // R3 and R4
    itype_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((c_op == OP_ORI) || (c_op == OP_LW)) && (c_rt != '0))
        |-> (dbg_rf_we && (dbg_rf_waddr == c_rt)));

    // R5
    store_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_op == OP_SW) |-> !dbg_rf_we);

    // R8
    unknown_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !c_known |-> !dbg_rf_we);

    // R8
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_op != OP_BEQ) |=> (dbg_pc == $past(dbg_pc) + XLEN'(4)));

    // R6
    branch_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_op == OP_BEQ) |=> ((dbg_pc == $past(dbg_pc) + XLEN'(4))
                           || (dbg_pc == $past(dbg_pc) + XLEN'(4) + $past(c_boff))));

endmodule

bind scd_core scd_core_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .dbg_pc       (dbg_pc),
    .dbg_instr    (dbg_instr),
    .dbg_rf_we    (dbg_rf_we),
    .dbg_rf_waddr (dbg_rf_waddr),
    .dbg_rf_wdata (dbg_rf_wdata)
);

// File: tb/scd_core_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: an instruction-level model steps the loaded program and
// pushes one expected item per cycle; a monitor pops and compares it against
// the observation outputs in the middle of the low clock phase.
module scd_core_bench;

    typedef struct {
        logic [31:0] pc;
        logic [31:0] instr;
        logic        we;
        logic [4:0]  waddr;
        logic [31:0] wdata;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_ld_we = 1'b0;
    logic [7:0]  imem_ld_idx = '0;
    logic [31:0] imem_ld_data = '0;
    logic        dmem_ld_we = 1'b0;
    logic [7:0]  dmem_ld_idx = '0;
    logic [31:0] dmem_ld_data = '0;
    logic [31:0] dbg_pc;
    logic [31:0] dbg_instr;
    logic        dbg_rf_we;
    logic [4:0]  dbg_rf_waddr;
    logic [31:0] dbg_rf_wdata;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] ref_im [256];
    logic [31:0] ref_dm [256];
    logic [31:0] ref_rf [32];
    logic [31:0] ref_pc;
    exp_t        sb_q [$];
    event        mon_start;
    event        mon_done;

    always #4 clk = ~clk;

    scd_core u_scd_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .imem_ld_we   (imem_ld_we),
        .imem_ld_idx  (imem_ld_idx),
        .imem_ld_data (imem_ld_data),
        .dmem_ld_we   (dmem_ld_we),
        .dmem_ld_idx  (dmem_ld_idx),
        .dmem_ld_data (dmem_ld_data),
        .dbg_pc       (dbg_pc),
        .dbg_instr    (dbg_instr),
        .dbg_rf_we    (dbg_rf_we),
        .dbg_rf_waddr (dbg_rf_waddr),
        .dbg_rf_wdata (dbg_rf_wdata)
    );

    function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt,
                                          logic [4:0] rd, logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs,
                                          logic [4:0] rt, logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] sext16(logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference step: one instruction by the requirement text.
    task automatic ref_step(output exp_t e);
        logic [31:0] ins, a, b, v, addr, nxt;
        logic [4:0]  wa;
        logic        w;
        ins = ref_im[ref_pc[9:2]];
        a   = (ins[25:21] == 0) ? 32'h0 : ref_rf[ins[25:21]];
        b   = (ins[20:16] == 0) ? 32'h0 : ref_rf[ins[20:16]];
        nxt = ref_pc + 4;
        w = 1'b0; wa = '0; v = '0;
        e.req = "R8";
        case (ins[31:26])
            6'h00: begin
                if (ins[5:0] == 6'h21) begin w = 1; wa = ins[15:11]; v = a + b; e.req = "R2"; end
                else if (ins[5:0] == 6'h23) begin w = 1; wa = ins[15:11]; v = a - b; e.req = "R2"; end
            end
            6'h0D: begin w = 1; wa = ins[20:16]; v = a | {16'h0, ins[15:0]}; e.req = "R3"; end
            6'h23: begin
                addr = a + sext16(ins[15:0]);
                w = 1; wa = ins[20:16]; v = ref_dm[addr[9:2]]; e.req = "R4";
            end
            6'h2B: begin
                addr = a + sext16(ins[15:0]);
                ref_dm[addr[9:2]] = b; e.req = "R5";
            end
            6'h04: begin
                e.req = "R6";
                if (a == b) nxt = nxt + {sext16(ins[15:0]), 2'b00};
            end
            default: ;
        endcase
        if (w && wa == 0) e.req = "R7";
        e.pc    = ref_pc;
        e.instr = ins;
        e.we    = w && (wa != 0);
        e.waddr = wa;
        e.wdata = v;
        if (e.we) ref_rf[wa] = v;
        ref_pc = nxt;
    endtask

    // Driver: model n steps and queue the expectations.
    task automatic push_run(int n);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            ref_step(e);
            sb_q.push_back(e);
        end
    endtask

    task automatic load_im(int idx, logic [31:0] w);
        @(negedge clk);
        imem_ld_we = 1'b1; imem_ld_idx = idx[7:0]; imem_ld_data = w;
        ref_im[idx] = w;
    endtask

    task automatic load_dm(int idx, logic [31:0] w);
        @(negedge clk);
        dmem_ld_we = 1'b1; dmem_ld_idx = idx[7:0]; dmem_ld_data = w;
        ref_dm[idx] = w;
    endtask

    // Monitor: pops one item per cycle and compares.
    initial begin
        forever begin
            @(mon_start);
            while (sb_q.size() > 0) begin
                exp_t e;
                #2;
                e = sb_q.pop_front();
                chk(e.req, "pc", dbg_pc, e.pc);
                chk("R9", "instr", dbg_instr, e.instr);
                chk(e.req, "rf_we", {31'b0, dbg_rf_we}, {31'b0, e.we});
                if (e.we) begin
                    chk(e.req, "rf_waddr", {27'b0, dbg_rf_waddr}, {27'b0, e.waddr});
                    chk(e.req, "rf_wdata", dbg_rf_wdata, e.wdata);
                end
                @(negedge clk);
            end
            ->mon_done;
        end
    end

    // Watchdog.
    initial begin
        #(8 * 10000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Stimulus.
    initial begin
        for (int i = 0; i < 32; i++) ref_rf[i] = '0;
        for (int i = 0; i < 256; i++) begin ref_im[i] = 'x; ref_dm[i] = 'x; end
        ref_pc = '0;

        load_im(0,  enc_i(6'h0D, 0, 1, 16'h8005));   // R3 zero-extension
        load_im(1,  enc_i(6'h0D, 0, 2, 16'h0010));
        load_im(2,  enc_r(1, 2, 3, 6'h21));           // R2 add
        load_im(3,  enc_r(2, 1, 4, 6'h23));           // R2 subtract wraps
        load_im(4,  enc_i(6'h23, 2, 5, 16'h0004));    // R4 positive offset
        load_im(5,  enc_i(6'h23, 2, 6, 16'hFFFC));    // R4 negative offset
        load_im(6,  enc_i(6'h2B, 2, 4, 16'h0008));    // R5 store
        load_im(7,  enc_i(6'h23, 0, 7, 16'h0018));    // R5 read back
        load_im(8,  enc_r(1, 2, 0, 6'h21));           // R7 write to r0
        load_im(9,  enc_i(6'h0D, 0, 0, 16'h1234));    // R7 write to r0
        load_im(10, enc_r(0, 1, 8, 6'h21));           // R7 r0 reads zero
        load_im(11, enc_i(6'h04, 1, 2, 16'h0005));    // R6 not taken
        load_im(12, enc_i(6'h04, 8, 1, 16'h0002));    // R6 taken forward
        load_im(13, enc_i(6'h0D, 0, 9, 16'hDEAD));
        load_im(14, enc_i(6'h0D, 0, 9, 16'hBEEF));
        load_im(15, enc_i(6'h3F, 1, 10, 16'h7777));   // R8 unknown opcode
        load_im(16, enc_r(1, 2, 11, 6'h20));          // R8 unknown funct
        load_im(17, enc_i(6'h04, 0, 0, 16'hFFFF));    // R6 backward loop
        load_dm(3, 32'hCAFE_F00D);
        load_dm(5, 32'h1234_5678);
        @(negedge clk);
        imem_ld_we = 1'b0; dmem_ld_we = 1'b0;
        @(negedge clk);
        #2;
        // R1 reset state, R9 preload visible at fetch
        chk("R1", "pc in reset", dbg_pc, 32'h0);
        chk("R1", "rf_we in reset", {31'b0, dbg_rf_we}, 32'h0);
        chk("R9", "preloaded word", dbg_instr, ref_im[0]);

        push_run(24);
        @(negedge clk);
        rst_n = 1'b1;
        ->mon_start;
        @(mon_done);

        // R1 mid-run reset: PC returns to 0, state is kept
        rst_n = 1'b0;
        @(negedge clk);
        #2;
        chk("R1", "pc after mid reset", dbg_pc, 32'h0);
        chk("R1", "rf_we during reset", {31'b0, dbg_rf_we}, 32'h0);
        ref_pc = '0;
        push_run(20);
        @(negedge clk);
        rst_n = 1'b1;
        ->mon_start;
        @(mon_done);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule